// File: doc/BRIEF.md
# Sequential Multi-Word Magnitude Comparator

This block decides whether operand A is less than, equal to or greater than operand B. Both are wide unsigned numbers held in two external word-addressed memories with synchronous read ports. The block never sees either operand whole. It drives one address bus that feeds the read ports of both memories, so word k of A and word k of B come back together, one clock after the address was driven. It then folds each pair of words into a running verdict in which the most significant differing word decides.

A one-cycle pulse on `start_i` starts a comparison while the block is idle. `ready_o` drops on the next cycle. It rises again on the same edge that loads the three result flags, and the flags keep that value until the next comparison finishes. The operand length (`NUM_WORDS`), word width and address width are parameters. `SCAN_DOWN` chooses the scan order. With a downward scan the first differing word is latched and later words are ignored. With an upward scan every differing word overwrites the earlier verdict. Both orders take the same number of cycles.

Top module: `seq_mag_cmp`

## Requirements
- R1: While reset is asserted and after it is released, `ready_o` is 1 and the flags read lt_o=0, eq_o=1, gt_o=0 until the first comparison completes.
- R2: After an accepted start, `rd_addr_o` presents each word address from 0 to NUM_WORDS-1 once, one per cycle, stepping by one. The first address is NUM_WORDS-1 when SCAN_DOWN=1 and 0 when SCAN_DOWN=0, and the address never reaches NUM_WORDS or above. Address 0 holds the least significant word.
- R3: A word pair on `opa_word_i`/`opb_word_i` is taken as the data for the address driven one cycle earlier.
- R4: `ready_o` is 0 on the cycle after a start is accepted, stays 0 for exactly NUM_WORDS+1 cycles, and then returns to 1. It stays 1 while no start arrives.
- R5: Exactly one of `lt_o`, `eq_o`, `gt_o` is 1 in every cycle.
- R6: With the operands taken as unsigned numbers, lt_o=1 means A<B, eq_o=1 means A==B and gt_o=1 means A>B. The most significant differing word decides, whatever the lower words hold.
- R7: The result is correct when the operands differ by +1 or -1 in only the lowest, only a middle, or only the top word.
- R8: A start pulse that arrives while `ready_o` is 0 is ignored. The comparison in progress keeps its timing and its result.
- R9: The flags change only on the edge where `ready_o` rises. Between comparisons they hold, even if the memory contents change.
- R10: Both scan orders (SCAN_DOWN=0 and 1) give identical results and identical latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle pulse that starts a comparison when idle |
| ready_o | output | 1 | High when idle; the flags are valid while high |
| rd_addr_o | output | ADDR_W | Word address shared by both operand memories |
| opa_word_i | input | WORD_W | Read data from the operand A memory |
| opb_word_i | input | WORD_W | Read data from the operand B memory |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B |
| gt_o | output | 1 | A is greater than B |

## Verification
A small upward-scanning instance (three 2-bit words) is swept over every operand pair. A design that let a lower differing word override a higher one would give the wrong verdict on pairs whose top words disagree, and the sweep holds many such pairs. A full-size downward-scanning instance gets ±1 differences in the bottom, a middle and the top word, a pair where a higher word decides against all-ones lower words, and a start pulse sent while busy. A one-cycle error in read alignment would compare each word with its neighbour's address. A restart taken while busy would lengthen the busy window. Flags that leaked between runs would follow memory rewrites made while idle.

// File: rtl/seq_mag_cmp_pkg.sv
package seq_mag_cmp_pkg;
   typedef enum logic [1:0] {
      VERD_EQ = 2'd0,
      VERD_LT = 2'd1,
      VERD_GT = 2'd2
   } verdict_t;
endpackage

// File: rtl/seq_mag_cmp_seq.sv
// Address sequencer: one address per cycle, plus a valid/last pipeline
// delayed by the synchronous read latency of the operand memories.
module seq_mag_cmp_seq #(
   parameter int NUM_WORDS = 8,
   parameter int ADDR_W    = 3,
   parameter bit SCAN_DOWN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              vld_o,
   output logic              last_o
);
   localparam logic [ADDR_W-1:0] LAST_CNT   = ADDR_W'(NUM_WORDS - 1);
   localparam logic [ADDR_W-1:0] FIRST_ADDR = SCAN_DOWN ? ADDR_W'(NUM_WORDS - 1) : '0;

   logic              issuing_q;
   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_step;
   logic              vld_q;
   logic              last_q;

   generate
      if (SCAN_DOWN) begin : g_down
         assign addr_step = addr_q - 1'b1;
      end else begin : g_up
         assign addr_step = addr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issuing_q <= 1'b0;
         cnt_q     <= '0;
         addr_q    <= FIRST_ADDR;
         vld_q     <= 1'b0;
         last_q    <= 1'b0;
      end else begin
         vld_q  <= issuing_q;
         last_q <= issuing_q && (cnt_q == LAST_CNT);
         if (accept_i) begin
            issuing_q <= 1'b1;
            cnt_q     <= '0;
            addr_q    <= FIRST_ADDR;
         end else if (issuing_q) begin
            if (cnt_q == LAST_CNT) begin
               issuing_q <= 1'b0;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
               addr_q <= addr_step;
            end
         end
      end
   end

   assign rd_addr_o = addr_q;
   assign vld_o     = vld_q;
   assign last_o    = last_q;

   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_addr_o) < NUM_WORDS); // R2

   generate
      if (SCAN_DOWN) begin : g_chk_down
         AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (issuing_q && $past(issuing_q)) |-> (rd_addr_o == $past(rd_addr_o) - 1'b1)); // R2
      end else begin : g_chk_up
         AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (issuing_q && $past(issuing_q)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1)); // R2
      end
   endgenerate

   AST_VLD_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      issuing_q |=> vld_o); // R3
endmodule

// File: rtl/seq_mag_cmp_word.sv
// Single word-pair magnitude decision.
module seq_mag_cmp_word
   import seq_mag_cmp_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] a_i,
   input  logic [WORD_W-1:0] b_i,
   output verdict_t          verd_o
);
   always_comb begin
      if (a_i < b_i)      verd_o = VERD_LT;
      else if (a_i > b_i) verd_o = VERD_GT;
      else                verd_o = VERD_EQ;
   end
endmodule

// File: rtl/seq_mag_cmp_acc.sv
// Verdict accumulator; the merge rule depends on the scan direction.
module seq_mag_cmp_acc
   import seq_mag_cmp_pkg::*;
#(
   parameter bit SCAN_DOWN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clear_i,
   input  logic     vld_i,
   input  logic     last_i,
   input  verdict_t word_i,
   output verdict_t result_o
);
   verdict_t acc_q;
   verdict_t acc_next;
   verdict_t result_q;

   generate
      if (SCAN_DOWN) begin : g_first_diff
         // Most significant word arrives first: keep the first difference.
         assign acc_next = (acc_q == VERD_EQ) ? word_i : acc_q;
      end else begin : g_last_diff
         // Most significant word arrives last: any difference overrides.
         assign acc_next = (word_i == VERD_EQ) ? acc_q : word_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= VERD_EQ;
         result_q <= VERD_EQ;
      end else begin
         if (clear_i)    acc_q <= VERD_EQ;
         else if (vld_i) acc_q <= acc_next;
         if (vld_i && last_i) result_q <= acc_next;
      end
   end

   assign result_o = result_q;

   generate
      if (SCAN_DOWN) begin : g_chk
         AST_FIRST_DIFF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_i && !clear_i && acc_q != VERD_EQ) |=> (acc_q == $past(acc_q))); // R6
      end
   endgenerate
endmodule

// File: rtl/seq_mag_cmp.sv
module seq_mag_cmp
   import seq_mag_cmp_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 8,
   parameter int ADDR_W    = 3,
   parameter bit SCAN_DOWN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              ready_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [WORD_W-1:0] opa_word_i,
   input  logic [WORD_W-1:0] opb_word_i,
   output logic              lt_o,
   output logic              eq_o,
   output logic              gt_o
);
   generate
      if (NUM_WORDS < 1 || NUM_WORDS > (1 << ADDR_W)) begin : g_bad_words
         $error("seq_mag_cmp: NUM_WORDS must be 1..2**ADDR_W");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("seq_mag_cmp: WORD_W must be positive");
      end
   endgenerate

   logic     ready_q;
   logic     accept;
   logic     vld;
   logic     last;
   verdict_t word_verd;
   verdict_t result;

   assign accept = start_i && ready_q;

   seq_mag_cmp_seq #(
      .NUM_WORDS (NUM_WORDS),
      .ADDR_W    (ADDR_W),
      .SCAN_DOWN (SCAN_DOWN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .rd_addr_o (rd_addr_o),
      .vld_o     (vld),
      .last_o    (last)
   );

   seq_mag_cmp_word #(
      .WORD_W (WORD_W)
   ) u_word (
      .a_i    (opa_word_i),
      .b_i    (opb_word_i),
      .verd_o (word_verd)
   );

   seq_mag_cmp_acc #(
      .SCAN_DOWN (SCAN_DOWN)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (accept),
      .vld_i    (vld),
      .last_i   (last),
      .word_i   (word_verd),
      .result_o (result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ready_q <= 1'b1;
      else if (accept)       ready_q <= 1'b0;
      else if (vld && last)  ready_q <= 1'b1;
   end

   assign ready_o = ready_q;
   assign lt_o    = (result == VERD_LT);
   assign eq_o    = (result == VERD_EQ);
   assign gt_o    = (result == VERD_GT);

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && start_i) |=> !ready_o); // R4
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !start_i) |=> ready_o); // R4
   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({lt_o, eq_o, gt_o}) == 1); // R5
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({lt_o, eq_o, gt_o}) |-> $rose(ready_o)); // R9
endmodule

// File: tb/seq_mag_cmp_bench.sv
module seq_mag_cmp_bench;
   localparam int BW = 32, BN = 8, BA = 3;
   localparam int SW = 2,  SN = 3, SA = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   logic start;
   logic use_small;

   logic [BW-1:0] mem_ba [0:(1<<BA)-1];
   logic [BW-1:0] mem_bb [0:(1<<BA)-1];
   logic [SW-1:0] mem_sa [0:(1<<SA)-1];
   logic [SW-1:0] mem_sb [0:(1<<SA)-1];

   logic [BA-1:0] addr_b;
   logic [SA-1:0] addr_s;
   logic [BW-1:0] qa_b, qb_b;
   logic [SW-1:0] qa_s, qb_s;
   logic rdy_b, lt_b, eq_b, gt_b;
   logic rdy_s, lt_s, eq_s, gt_s;

   always_ff @(posedge clk) begin
      qa_b <= mem_ba[addr_b];
      qb_b <= mem_bb[addr_b];
      qa_s <= mem_sa[addr_s];
      qb_s <= mem_sb[addr_s];
   end

   seq_mag_cmp #(.WORD_W(BW), .NUM_WORDS(BN), .ADDR_W(BA), .SCAN_DOWN(1'b1)) u_seq_mag_cmp (
      .clk(clk), .rst_n(rst_n), .start_i(start && !use_small), .ready_o(rdy_b),
      .rd_addr_o(addr_b), .opa_word_i(qa_b), .opb_word_i(qb_b),
      .lt_o(lt_b), .eq_o(eq_b), .gt_o(gt_b));

   seq_mag_cmp #(.WORD_W(SW), .NUM_WORDS(SN), .ADDR_W(SA), .SCAN_DOWN(1'b0)) u_seq_mag_cmp_small (
      .clk(clk), .rst_n(rst_n), .start_i(start && use_small), .ready_o(rdy_s),
      .rd_addr_o(addr_s), .opa_word_i(qa_s), .opb_word_i(qb_s),
      .lt_o(lt_s), .eq_o(eq_s), .gt_o(gt_s));

   logic       cur_rdy;
   logic [2:0] cur_flags;
   logic [3:0] cur_addr;
   assign cur_rdy   = use_small ? rdy_s : rdy_b;
   assign cur_flags = use_small ? {lt_s, eq_s, gt_s} : {lt_b, eq_b, gt_b};
   assign cur_addr  = use_small ? 4'(addr_s) : 4'(addr_b);

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] expect3(input logic lt, input logic eq);
      return lt ? 3'b100 : (eq ? 3'b010 : 3'b001);
   endfunction

   task automatic run(input bit glitch, output int lows, output logic [3:0] first_addr);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      first_addr = cur_addr;
      lows = 0;
      while (!cur_rdy && lows < 100) begin
         lows++;
         start = (glitch && lows == 3);
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic big_case(input string tag, input logic [BW*BN-1:0] x,
                           input logic [BW*BN-1:0] y, input bit glitch);
      int lows;
      logic [3:0] fa;
      for (int i = 0; i < BN; i++) begin
         mem_ba[i] = x[i*BW +: BW];
         mem_bb[i] = y[i*BW +: BW];
      end
      run(glitch, lows, fa);
      chk({tag, " R4 busy cycles"}, 32'(lows), 32'(BN + 1));
      chk({tag, " R2 first addr"}, 32'(fa), 32'(BN - 1));
      chk({tag, " R6 flags"}, 32'(cur_flags), 32'(expect3(x < y, x == y)));
   endtask

   initial begin
      logic [BW*BN-1:0] base;
      logic [BW*BN-1:0] one;
      int lows;
      logic [3:0] fa;
      rst_n = 1'b0;
      start = 1'b0;
      use_small = 1'b0;
      for (int i = 0; i < (1<<BA); i++) begin mem_ba[i] = '0; mem_bb[i] = '0; end
      for (int i = 0; i < (1<<SA); i++) begin mem_sa[i] = '0; mem_sb[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", 32'(rdy_b), 32'd1);
      chk("R1 flags in reset", 32'({lt_b, eq_b, gt_b}), 32'b010);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 ready after reset", 32'({rdy_b, rdy_s}), 32'b11);
      chk("R1 flags after reset", 32'({lt_s, eq_s, gt_s}), 32'b010);

      base = 256'h6B21_90E4_3C7D_A155_0F93_2E8B_D472_19C6_8835_7A0D_E2B4_4F61_1D98_C3A7_5E02_B79F;
      big_case("R6 equal", base, base, 1'b0);
      for (int k = 0; k < 3; k++) begin
         int w;
         w = (k == 0) ? 0 : ((k == 1) ? 4 : 7);
         one = '0;
         one[w*BW] = 1'b1;
         big_case($sformatf("R7 word%0d plus", w), base, base + one, 1'b0);
         big_case($sformatf("R7 word%0d minus", w), base, base - one, 1'b0);
      end
      big_case("R6 top word decides", {32'h1, {224{1'b1}}}, {32'h2, 224'b0}, 1'b0);
      big_case("R6 zero vs ones", '0, '1, 1'b0);
      big_case("R6 ones vs zero", '1, '0, 1'b0);
      big_case("R8 start while busy", base + 256'd5, base, 1'b1);

      // R9: rewrite memories while idle; flags and ready must not move
      for (int i = 0; i < BN; i++) begin mem_ba[i] = '0; mem_bb[i] = '1; end
      repeat (6) @(negedge clk);
      chk("R9 flags hold", 32'(cur_flags), 32'b001);
      chk("R9 ready hold R4", 32'(cur_rdy), 32'd1);

      // R10 / R3: exhaustive sweep on the small upward-scanning instance
      use_small = 1'b1;
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 64; b++) begin
            for (int i = 0; i < SN; i++) begin
               mem_sa[i] = SW'(a >> (i*SW));
               mem_sb[i] = SW'(b >> (i*SW));
            end
            run(1'b0, lows, fa);
            chk($sformatf("R10 a=%0d b=%0d flags", a, b), 32'(cur_flags),
                32'(expect3(a < b, a == b)));
            if (a == b) begin
               chk("R10 latency", 32'(lows), 32'(SN + 1));
               chk("R2 first addr upward", 32'(fa), 32'd0);
            end
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog R4 actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule